// File: doc/BRIEF.md
# Address Translation Mode Selector

This block is the first step of translating a virtual address. For each request it chooses one of four outcomes. The address can pass straight through, or be translated by one of four direct-mapped windows. It can be refused because its upper bits are not a proper sign extension, or it can be handed on to the TLB path. The TLB is a separate block. Passthrough and window hits return a physical address with full read, write and execute permission. A request bound for the TLB carries its virtual address out on a request strobe.

A small two-state controller runs the block. In state `ST_IDLE` it raises `req_ready`. It moves to `ST_RESOLVE` on the accept transition, taken when `req_valid` is high, and latches the address, the privilege, the width mode and the two mode bits. In `ST_RESOLVE` it evaluates the request and loads the response registers. It then takes the publish transition back to `ST_IDLE` without condition. The response therefore appears for exactly one cycle, two clock edges after acceptance. The window configuration words are read live in `ST_RESOLVE`, so they must stay stable from acceptance until the response.

Top module: `xlat_mode_sel`

## Requirements
- R1: While reset is held, and in the cycle after it, `rsp_valid` and `rsp_tlb_req` are 0, `rsp_code`, `rsp_paddr`, `rsp_perm` and `rsp_win` are 0, and `req_ready` is 1.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for one cycle, and inputs offered during that cycle are ignored. `rsp_valid` is 1 for exactly the one cycle that follows, and `req_ready` is already 1 again in that cycle.
- R3: If the request has mode bits da=1 and pg=0, the response is code 0 (match) with `rsp_paddr` equal to the address masked to its low PA_W (48) bits, `rsp_perm` = 3'b111, and `rsp_win` = 0. The windows and the sign check have no effect in this case.
- R4: A window is enabled only if a privilege mask ANDed with its configuration word gives a non-zero result. The mask has bit 0 set for a kernel request (`req_user`=0) and bit 3 set for a user request (`req_user`=1).
- R5: In 64-bit mode (`req_wide`=1), a window segment matches when address bits [63:60] equal configuration bits [63:60].
- R6: In 32-bit mode, a window segment matches when address bits [31:29] equal configuration bits [31:29]. The physical address is then configuration bits [27:25] placed above address bits [28:0], with all higher bits zero.
- R7: A window hit in 64-bit mode gives a physical address equal to the virtual address masked to its low VA_W (48) bits.
- R8: When several windows hit, the one with the lowest index wins, and `rsp_win` reports that index. Any response that is not a window hit reports `rsp_win` = 0.
- R9: A window hit gives code 0 and `rsp_perm` = 3'b111, where bit 0 is read, bit 1 is write and bit 2 is execute. Codes are only ever 0, 1 or 2.
- R10: With no window hit and no passthrough, address bits [63:48] must be all zeros or all ones. If they are not, the response is code 1 (bad address), with `rsp_paddr`, `rsp_perm` and `rsp_tlb_req` all 0.
- R11: An address that passes the check in R10 gives code 2 (needs TLB). `rsp_tlb_req` is high in the response cycle only, with `rsp_tlb_vaddr` equal to the request address and `rsp_paddr` and `rsp_perm` equal to 0.
- R12: The mode combinations other than da=1 with pg=0 (including da=1 with pg=1) take the window and sign-check path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can accept a request (state ST_IDLE) |
| req_vaddr | input | ADDR_W | Virtual address of the request |
| req_user | input | 1 | 1 = user privilege, 0 = kernel privilege |
| req_wide | input | 1 | 1 = 64-bit address mode, 0 = 32-bit mode |
| req_da | input | 1 | Direct-address mode bit |
| req_pg | input | 1 | Paging mode bit |
| win_cfg | input | NWIN*ADDR_W | Window configuration words; window i is in bits [i*ADDR_W +: ADDR_W] |
| rsp_valid | output | 1 | Response registers are valid for this cycle |
| rsp_code | output | 2 | 0 match, 1 bad address, 2 needs TLB |
| rsp_paddr | output | ADDR_W | Physical address on a match, else 0 |
| rsp_perm | output | 3 | Permissions {exec, write, read} on a match, else 0 |
| rsp_win | output | WIN_IDX_W | Index of the window that hit |
| rsp_tlb_req | output | 1 | Request strobe toward the TLB path |
| rsp_tlb_vaddr | output | ADDR_W | Address forwarded to the TLB path, else 0 |

## Verification
The hardest situation to reach is one where the outcome depends on how several independent fields interact. Examples are a window whose segment matches but whose privilege bit is for the other mode, two windows that both match so that priority decides, and an address right at the sign-extension boundary. Directed requests build these cases: configuration words are crafted so that windows overlap, privilege mismatches fall through to the TLB or bad-address path, and passthrough mode is tried with windows that would otherwise hit. A stretch with `req_valid` held high while the address changes every cycle shows that input offered during `ST_RESOLVE` is dropped. A randomized run draws segments from a small set, so that hits, overlaps and sign-check failures happen often. A behavioural model compares every cycle against the design.

// File: rtl/xlat_sel_pkg.sv
package xlat_sel_pkg;

    typedef enum logic [1:0] {
        OUT_MATCH   = 2'd0,
        OUT_BADADDR = 2'd1,
        OUT_TLB     = 2'd2
    } xlat_out_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_RESOLVE = 1'b1
    } xlat_state_e;

    localparam int PERM_W = 3;
    localparam logic [PERM_W-1:0] PERM_RWX  = 3'b111;
    localparam logic [PERM_W-1:0] PERM_NONE = 3'b000;

endpackage

// File: rtl/xlat_window.sv
module xlat_window #(
    parameter int ADDR_W     = 64,
    parameter int VA_W       = 48,
    parameter int SEG64_LSB  = 60,
    parameter int SEG32_LSB  = 29,
    parameter int SEG32_W    = 3,
    parameter int PSEG32_LSB = 25,
    parameter int KERN_BIT   = 0,
    parameter int USER_BIT   = 3
) (
    input  logic [ADDR_W-1:0] cfg,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              is_user,
    input  logic              wide,
    output logic              hit,
    output logic [ADDR_W-1:0] paddr
);
    localparam int SEG32_MSB  = SEG32_LSB + SEG32_W - 1;
    localparam int PSEG32_MSB = PSEG32_LSB + SEG32_W - 1;
    localparam int PAD32_W    = ADDR_W - SEG32_LSB - SEG32_W;
    localparam int PAD64_W    = ADDR_W - VA_W;

    logic [ADDR_W-1:0] priv_mask;
    logic              priv_ok;
    logic              seg_ok;
    logic [ADDR_W-1:0] pa_wide;
    logic [ADDR_W-1:0] pa_narrow;
    logic              unused_bits;

    always_comb begin
        priv_mask           = '0;
        priv_mask[KERN_BIT] = ~is_user;
        priv_mask[USER_BIT] = is_user;
    end

    assign priv_ok = |(priv_mask & cfg);

    assign seg_ok = wide ? (vaddr[ADDR_W-1:SEG64_LSB] == cfg[ADDR_W-1:SEG64_LSB])
                         : (vaddr[SEG32_MSB:SEG32_LSB] == cfg[SEG32_MSB:SEG32_LSB]);

    assign pa_wide   = {{PAD64_W{1'b0}}, vaddr[VA_W-1:0]};
    assign pa_narrow = {{PAD32_W{1'b0}}, cfg[PSEG32_MSB:PSEG32_LSB], vaddr[SEG32_LSB-1:0]};

    assign hit   = priv_ok & seg_ok;
    assign paddr = wide ? pa_wide : pa_narrow;

    assign unused_bits = ^{cfg, vaddr};

endmodule

// File: rtl/xlat_first_hit.sv
module xlat_first_hit #(
    parameter int N = 4,
    parameter int W = 64,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   hits,
    input  logic [N*W-1:0] cand,
    output logic           any,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]   sel
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
                sel = cand[i*W +: W];
            end
        end
    end

endmodule

// File: rtl/xlat_canon_chk.sv
module xlat_canon_chk #(
    parameter int ADDR_W = 64,
    parameter int VA_W   = 48,
    parameter int EXT_W  = 16
) (
    input  logic [ADDR_W-1:0] vaddr,
    output logic              ok
);
    logic [EXT_W-1:0] ext;
    logic             unused_bits;

    assign ext         = vaddr[VA_W+EXT_W-1:VA_W];
    assign ok          = (&ext) | ~(|ext);
    assign unused_bits = ^vaddr;

endmodule

// File: rtl/xlat_mode_sel.sv
module xlat_mode_sel
    import xlat_sel_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int VA_W       = 48,
    parameter int PA_W       = 48,
    parameter int EXT_W      = 16,
    parameter int NWIN       = 4,
    parameter int SEG64_LSB  = 60,
    parameter int SEG32_LSB  = 29,
    parameter int SEG32_W    = 3,
    parameter int PSEG32_LSB = 25,
    parameter int KERN_BIT   = 0,
    parameter int USER_BIT   = 3,
    localparam int WIN_IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_vaddr,
    input  logic                   req_user,
    input  logic                   req_wide,
    input  logic                   req_da,
    input  logic                   req_pg,
    input  logic [NWIN*ADDR_W-1:0] win_cfg,
    output logic                   rsp_valid,
    output logic [1:0]             rsp_code,
    output logic [ADDR_W-1:0]      rsp_paddr,
    output logic [PERM_W-1:0]      rsp_perm,
    output logic [WIN_IDX_W-1:0]   rsp_win,
    output logic                   rsp_tlb_req,
    output logic [ADDR_W-1:0]      rsp_tlb_vaddr
);
    localparam int PA_PAD_W = ADDR_W - PA_W;

    xlat_state_e state_q, state_d;

    logic [ADDR_W-1:0] cap_vaddr;
    logic              cap_user;
    logic              cap_wide;
    logic              cap_da;
    logic              cap_pg;

    logic [NWIN-1:0]        win_hit;
    logic [NWIN*ADDR_W-1:0] win_pa;
    logic                   any_hit;
    logic [WIN_IDX_W-1:0]   hit_idx;
    logic [ADDR_W-1:0]      hit_pa;
    logic                   canon_ok;
    logic                   direct;
    logic [ADDR_W-1:0]      direct_pa;

    xlat_out_e             dec_code;
    logic [ADDR_W-1:0]     dec_paddr;
    logic [PERM_W-1:0]     dec_perm;
    logic [WIN_IDX_W-1:0]  dec_win;
    logic                  dec_tlb;

    // ---------------- window decoders, one per window ----------------
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        xlat_window #(
            .ADDR_W    (ADDR_W),
            .VA_W      (VA_W),
            .SEG64_LSB (SEG64_LSB),
            .SEG32_LSB (SEG32_LSB),
            .SEG32_W   (SEG32_W),
            .PSEG32_LSB(PSEG32_LSB),
            .KERN_BIT  (KERN_BIT),
            .USER_BIT  (USER_BIT)
        ) u_win (
            .cfg    (win_cfg[g*ADDR_W +: ADDR_W]),
            .vaddr  (cap_vaddr),
            .is_user(cap_user),
            .wide   (cap_wide),
            .hit    (win_hit[g]),
            .paddr  (win_pa[g*ADDR_W +: ADDR_W])
        );
    end

    xlat_first_hit #(
        .N(NWIN),
        .W(ADDR_W)
    ) u_prio (
        .hits(win_hit),
        .cand(win_pa),
        .any (any_hit),
        .idx (hit_idx),
        .sel (hit_pa)
    );

    xlat_canon_chk #(
        .ADDR_W(ADDR_W),
        .VA_W  (VA_W),
        .EXT_W (EXT_W)
    ) u_canon (
        .vaddr(cap_vaddr),
        .ok   (canon_ok)
    );

    // ---------------- outcome decision ----------------
    assign direct    = cap_da & ~cap_pg;
    assign direct_pa = {{PA_PAD_W{1'b0}}, cap_vaddr[PA_W-1:0]};

    always_comb begin
        dec_code  = OUT_MATCH;
        dec_paddr = '0;
        dec_perm  = PERM_NONE;
        dec_win   = '0;
        dec_tlb   = 1'b0;
        if (direct) begin
            dec_paddr = direct_pa;
            dec_perm  = PERM_RWX;
        end else if (any_hit) begin
            dec_paddr = hit_pa;
            dec_perm  = PERM_RWX;
            dec_win   = hit_idx;
        end else if (canon_ok) begin
            dec_code = OUT_TLB;
            dec_tlb  = 1'b1;
        end else begin
            dec_code = OUT_BADADDR;
        end
    end

    // ---------------- state register ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign req_ready = (state_q == ST_IDLE);

    // ---------------- request capture ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vaddr <= '0;
            cap_user  <= 1'b0;
            cap_wide  <= 1'b0;
            cap_da    <= 1'b0;
            cap_pg    <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            cap_vaddr <= req_vaddr;
            cap_user  <= req_user;
            cap_wide  <= req_wide;
            cap_da    <= req_da;
            cap_pg    <= req_pg;
        end
    end

    // ---------------- response registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_code      <= OUT_MATCH;
            rsp_paddr     <= '0;
            rsp_perm      <= PERM_NONE;
            rsp_win       <= '0;
            rsp_tlb_req   <= 1'b0;
            rsp_tlb_vaddr <= '0;
        end else begin
            unique case (state_q)
                ST_RESOLVE: begin
                    rsp_valid     <= 1'b1;
                    rsp_code      <= dec_code;
                    rsp_paddr     <= dec_paddr;
                    rsp_perm      <= dec_perm;
                    rsp_win       <= dec_win;
                    rsp_tlb_req   <= dec_tlb;
                    rsp_tlb_vaddr <= dec_tlb ? cap_vaddr : '0;
                end
                ST_IDLE: begin
                    rsp_valid     <= 1'b0;
                    rsp_code      <= OUT_MATCH;
                    rsp_paddr     <= '0;
                    rsp_perm      <= PERM_NONE;
                    rsp_win       <= '0;
                    rsp_tlb_req   <= 1'b0;
                    rsp_tlb_vaddr <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/xlat_mode_sel_chk.sv
module xlat_mode_sel_chk #(
    parameter int ADDR_W    = 64,
    parameter int WIN_IDX_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 rsp_valid,
    input logic [1:0]           rsp_code,
    input logic [ADDR_W-1:0]    rsp_paddr,
    input logic [2:0]           rsp_perm,
    input logic [WIN_IDX_W-1:0] rsp_win,
    input logic                 rsp_tlb_req
);
    // R2: acceptance drops ready for one cycle and the response is not yet out
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_valid));

    // R2: the busy cycle is followed by the response with ready restored
    p_resolve_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (rsp_valid && req_ready));

    // R2: the response lasts a single cycle
    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2: a response only follows a busy cycle
    p_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!req_ready));

    // R9: matches carry full permission, codes stay legal
    p_perm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd0) |-> (rsp_perm == 3'b111));

    p_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_code != 2'd3));

    // R10: bad address carries nothing
    p_bad_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd1) |-> (rsp_perm == 3'b000 && !rsp_tlb_req && rsp_paddr == '0));

    // R11: the TLB strobe only travels with a needs-TLB response
    p_tlb_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_tlb_req |-> (rsp_valid && rsp_code == 2'd2 && rsp_perm == 3'b000));

    // R8: window index is zero unless a match
    p_win_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'd0) |-> (rsp_win == '0));

    // R1: outside a response the strobes and permissions rest at zero
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_tlb_req && rsp_perm == 3'b000));

endmodule

bind xlat_mode_sel xlat_mode_sel_chk #(
    .ADDR_W   (ADDR_W),
    .WIN_IDX_W(WIN_IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .rsp_paddr  (rsp_paddr),
    .rsp_perm   (rsp_perm),
    .rsp_win    (rsp_win),
    .rsp_tlb_req(rsp_tlb_req)
);

// File: tb/test_xlat_mode_sel.sv
module test_xlat_mode_sel;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam logic [63:0] MASK48 = 64'h0000_FFFF_FFFF_FFFF;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic         req_ready;
    logic [63:0]  req_vaddr;
    logic         req_user;
    logic         req_wide;
    logic         req_da;
    logic         req_pg;
    logic [63:0]  cfg [4];
    logic [255:0] win_cfg;
    logic         rsp_valid;
    logic [1:0]   rsp_code;
    logic [63:0]  rsp_paddr;
    logic [2:0]   rsp_perm;
    logic [1:0]   rsp_win;
    logic         rsp_tlb_req;
    logic [63:0]  rsp_tlb_vaddr;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_tag = "R2";

    assign win_cfg = {cfg[3], cfg[2], cfg[1], cfg[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_mode_sel i_xlat_mode_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .req_user     (req_user),
        .req_wide     (req_wide),
        .req_da       (req_da),
        .req_pg       (req_pg),
        .win_cfg      (win_cfg),
        .rsp_valid    (rsp_valid),
        .rsp_code     (rsp_code),
        .rsp_paddr    (rsp_paddr),
        .rsp_perm     (rsp_perm),
        .rsp_win      (rsp_win),
        .rsp_tlb_req  (rsp_tlb_req),
        .rsp_tlb_vaddr(rsp_tlb_vaddr)
    );

    typedef struct {
        logic [1:0]  code;
        logic [63:0] pa;
        logic [2:0]  perm;
        logic [1:0]  win;
        logic        tlb;
        logic [63:0] tva;
    } exp_t;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] mkwin(bit k, bit u, logic [3:0] s64, logic [2:0] s32, logic [2:0] ps);
        logic [63:0] w = '0;
        w[0]      = k;
        w[3]      = u;
        w[63:60]  = s64;
        w[31:29]  = s32;
        w[27:25]  = ps;
        return w;
    endfunction

    function automatic exp_t predict(logic [63:0] va, bit user, bit wide, bit da, bit pg);
        exp_t e;
        e.code = 2'd0; e.pa = '0; e.perm = 3'b000; e.win = 2'd0; e.tlb = 1'b0; e.tva = '0;
        if (da && !pg) begin
            e.pa = va & MASK48;
            e.perm = 3'b111;
            return e;
        end
        for (int i = 0; i < 4; i++) begin
            bit en = user ? cfg[i][3] : cfg[i][0];
            bit sm = wide ? (va[63:60] == cfg[i][63:60]) : (va[31:29] == cfg[i][31:29]);
            if (en && sm) begin
                e.perm = 3'b111;
                e.win  = 2'(i);
                e.pa   = wide ? (va & MASK48) : {32'b0, cfg[i][27:25], va[28:0]};
                return e;
            end
        end
        if (va[63:48] == 16'h0000 || va[63:48] == 16'hFFFF) begin
            e.code = 2'd2;
            e.tlb  = 1'b1;
            e.tva  = va;
        end else begin
            e.code = 2'd1;
        end
        return e;
    endfunction

    // behavioural reference: busy flag and pending response
    bit    m_busy = 0;
    bit    m_pend = 0;
    exp_t  e_hold, e_cur;
    string t_hold = "R2", t_cur = "R2";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0;
            m_pend = 0;
        end else begin
            m_pend = 0;
            if (m_busy) begin
                m_busy = 0;
                m_pend = 1;
                e_cur  = e_hold;
                t_cur  = t_hold;
            end else if (req_valid) begin
                m_busy = 1;
                e_hold = predict(req_vaddr, req_user, req_wide, req_da, req_pg);
                t_hold = cur_tag;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(req_ready == !m_busy, "R2 ready", 64'(req_ready), 64'(!m_busy));
            chk(rsp_valid == m_pend, "R2 rsp_valid", 64'(rsp_valid), 64'(m_pend));
            if (m_pend) begin
                chk(rsp_code == e_cur.code, $sformatf("%s code", t_cur), 64'(rsp_code), 64'(e_cur.code));
                chk(rsp_paddr == e_cur.pa, $sformatf("%s paddr", t_cur), rsp_paddr, e_cur.pa);
                chk(rsp_perm == e_cur.perm, $sformatf("%s perm", t_cur), 64'(rsp_perm), 64'(e_cur.perm));
                chk(rsp_win == e_cur.win, $sformatf("%s window index", t_cur), 64'(rsp_win), 64'(e_cur.win));
                chk(rsp_tlb_req == e_cur.tlb, $sformatf("%s tlb strobe", t_cur), 64'(rsp_tlb_req), 64'(e_cur.tlb));
                chk(rsp_tlb_vaddr == e_cur.tva, $sformatf("%s tlb vaddr", t_cur), rsp_tlb_vaddr, e_cur.tva);
            end else begin
                chk(!rsp_tlb_req && rsp_perm == 3'b000, "R11 strobe idle", 64'(rsp_tlb_req), 64'd0);
            end
        end
    end

    task automatic do_req(input string tag, input logic [63:0] va, input bit user, input bit wide,
                          input bit da, input bit pg);
        @(negedge clk);
        cur_tag   = tag;
        req_vaddr = va;
        req_user  = user;
        req_wide  = wide;
        req_da    = da;
        req_pg    = pg;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired (R2 no progress) actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0;
        req_user = 1'b0; req_wide = 1'b1; req_da = 1'b0; req_pg = 1'b1;
        for (int i = 0; i < 4; i++) cfg[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        chk(req_ready == 1'b1, "R1 req_ready in reset", 64'(req_ready), 64'd1);
        chk(rsp_code == 2'd0 && rsp_paddr == '0 && rsp_perm == 3'b0 && rsp_win == 2'd0,
            "R1 response fields in reset", rsp_paddr, 64'd0);
        chk(rsp_tlb_req == 1'b0 && rsp_tlb_vaddr == '0, "R1 tlb fields in reset", rsp_tlb_vaddr, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 after reset", 64'(rsp_valid), 64'd0);

        // windows: 0 kernel seg 9, 1 user seg 9 & 32-bit seg 5, 2 both seg 9, 3 kernel seg A
        cfg[0] = mkwin(1, 0, 4'h9, 3'd1, 3'd6);
        cfg[1] = mkwin(0, 1, 4'h9, 3'd5, 3'd2);
        cfg[2] = mkwin(1, 1, 4'h9, 3'd5, 3'd7);
        cfg[3] = mkwin(1, 0, 4'hA, 3'd3, 3'd4);

        // R3: passthrough ignores windows and sign check
        do_req("R3", 64'h9123_4567_89AB_CDEF, 0, 1, 1, 0);
        do_req("R3", 64'h1234_ABCD_0000_1111, 1, 0, 1, 0);
        // R12: da=1 pg=1 goes to windows
        do_req("R12", 64'h9000_0000_0000_1000, 0, 1, 1, 1);
        do_req("R12", 64'h0000_1234_0000_0000, 0, 1, 0, 0);
        // R5 / R7: kernel 64-bit hit window 0
        do_req("R7", 64'h9FFF_0012_3456_7890, 0, 1, 0, 1);
        // R4 / R8: user, window 0 is kernel-only, windows 1 and 2 both match -> 1
        do_req("R4", 64'h9000_00AB_CDEF_0123, 1, 1, 0, 1);
        // R5: seg A only window 3 (kernel)
        do_req("R5", 64'hA000_0000_0000_0040, 0, 1, 0, 1);
        // R4: user seg A, no user window -> sign check fails -> bad
        do_req("R4", 64'hA000_0000_0000_0040, 1, 1, 0, 1);
        // R6: 32-bit user seg 5 -> window 1 pseg 2
        do_req("R6", 64'h0000_0000_BFFF_FFFF, 1, 0, 0, 1);
        // R6: 32-bit kernel seg 5 -> window 2 (window 1 user-only)
        do_req("R6", 64'h0000_0000_A000_0004, 0, 0, 0, 1);
        // R10: bad sign extension
        do_req("R10", 64'h0001_0000_0000_0000, 0, 1, 0, 1);
        do_req("R10", 64'hFFFE_FFFF_FFFF_FFFF, 1, 1, 0, 1);
        // R11: canonical, no window
        do_req("R11", 64'hFFFF_8000_0000_1234, 0, 1, 0, 1);
        do_req("R11", 64'h0000_7FFF_FFFF_F000, 1, 1, 0, 1);
        // R8: make window 0 also match for user -> lowest index wins
        cfg[0] = mkwin(1, 1, 4'h9, 3'd5, 3'd1);
        do_req("R8", 64'h9000_0000_0000_0001, 1, 1, 0, 1);
        do_req("R8", 64'h0000_0000_A000_0000, 1, 0, 0, 1);
        cfg[0] = mkwin(0, 0, 4'h9, 3'd5, 3'd1);
        do_req("R9", 64'h9000_0000_0000_0001, 0, 1, 0, 1);

        // R2: hold valid high, change address every cycle
        @(negedge clk);
        cur_tag   = "R2";
        req_valid = 1'b1;
        req_user = 1'b0; req_wide = 1'b1; req_da = 1'b0; req_pg = 1'b1;
        for (int k = 0; k < 12; k++) begin
            req_vaddr = (k % 3 == 0) ? 64'h9000_0000_0000_0000 + 64'(k)
                      : (k % 3 == 1) ? 64'h0002_0000_0000_0000 + 64'(k)
                      : 64'h0000_0000_0000_1000 + 64'(k);
            @(negedge clk);
        end
        req_valid = 1'b0;
        repeat (3) @(negedge clk);

        // randomized mix
        for (int n = 0; n < 300; n++) begin
            logic [63:0] va;
            logic [3:0]  segs [4];
            if (n % 10 == 0) begin
                for (int i = 0; i < 4; i++)
                    cfg[i] = mkwin($urandom_range(0, 1), $urandom_range(0, 1),
                                   4'($urandom_range(0, 3)) | ($urandom_range(0, 3) == 0 ? 4'hF : 4'h0),
                                   3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
            end
            segs[0] = 4'h0; segs[1] = 4'hF; segs[2] = 4'h1; segs[3] = 4'($urandom_range(0, 15));
            va = {32'($urandom), 32'($urandom)};
            va[63:60] = segs[$urandom_range(0, 3)];
            case ($urandom_range(0, 2))
                0: va[59:48] = (va[63:60] == 4'hF) ? 12'hFFF : 12'h000;
                1: va[59:48] = 12'h000;
                default: ;
            endcase
            do_req($urandom_range(0, 1) ? "R4" : "R5", va, $urandom_range(0, 1), $urandom_range(0, 3) != 0,
                   $urandom_range(0, 5) == 0, $urandom_range(0, 3) != 0);
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule